// File: doc/BRIEF.md
# DisplayPort Link Training Controller

This block trains a DisplayPort main link of up to four lanes. It runs clock recovery first and channel equalization second. Every access to the sink's configuration registers goes through a simple byte-wide read/write port, and an AUX channel engine outside this block carries each transfer. The block also drives the transmitter's per-lane voltage swing, pre-emphasis and training-pattern selection.

A pulse on `start` sets the sequence going. The block reads the sink's rate and lane capabilities, replacing odd values with defaults, and configures the sink. It then polls the sink's status, waiting a fixed number of cycles before each poll. While training it follows the sink's adjustment requests, and it gives up when a loop limit is hit or a level-3 request arrives too early. When training ends, `done` rises and `pass` gives the outcome. `link_rate` and `link_lanes` hold the settings that were used. A failure only ends the run: lowering the link rate and retrying is left to the caller.

Top module: `dp_link_trainer`

## Requirements
- R1: The rate capability byte is read from sink address 0x001. The value 0x06 or 0x0A is reported on `link_rate` and used; any other value is replaced by 0x06.
- R2: The lane capability is bits [4:0] of sink address 0x002. The value 1 or 2 is kept and any other value (including 0) gives 4 lanes. Only lanes below this count are written, adjusted and checked.
- R3: The start phase writes these values in this order: 0x01 to 0x600, the rate to 0x100, the lane count to 0x101, and 0x21 (pattern 1, scrambling off) to 0x102. It then writes 0x00 to 0x103+n for each active lane n. The transmitter is left at swing 0, pre-emphasis 1 and `tx_pattern` = 1.
- R4: Lane n's status and request nibble sits in byte n>>1 (status at 0x202/0x203, requests at 0x206/0x207), in the high nibble when n is odd. A request nibble holds swing in bits [1:0] and pre-emphasis in bits [3:2]. A lane setting byte holds swing in [1:0], a swing-max flag in bit 2, pre-emphasis in [4:3] and a pre-emphasis-max flag in bit 5. Each flag is set when its level is 3.
- R5: Clock recovery passes when status bit 0 is set on every active lane. The block then sets `tx_pattern` = 2, applies the requests (level 3 allowed), writes 0x22 to 0x102 and writes the new setting bytes.
- R6: When clock recovery has not passed, a request of level 3 for swing or pre-emphasis on any active lane ends training with `pass` = 0.
- R7: When clock recovery has not passed, a lane whose request equals its current transmitter setting adds one to its own repeat counter. Training fails at the poll on which a counter would reach MAX_CR; otherwise the requests are applied and written.
- R8: Equalization passes when bit 0 of 0x204 is set and every active lane shows status bits [2:0] all set. Every ending, pass or fail, writes 0x00 to 0x102 and sets `tx_pattern` = 0 before `done` rises. `pass` is high only together with `done`.
- R9: Each equalization poll that does not pass adds one to a single shared counter, and the requests are applied and written. A failing poll when the counter already equals MAX_EQ ends training with `pass` = 0.
- R10: During equalization, an active lane without status bit 0 set ends training with `pass` = 0.
- R11: Each read of 0x202 is preceded by at least POLL_WAIT cycles with no request.
- R12: After reset `busy`, `done`, `pass`, `aux_req` and `tx_pattern` are 0. `start` raises `busy` on the next cycle and clears `done`. A request holds its address steady until `aux_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a training run (sampled while idle) |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training ended; held until the next start |
| pass | output | 1 | Training succeeded, valid with done |
| link_rate | output | 8 | Rate code in use |
| link_lanes | output | 3 | Lane count in use |
| aux_req | output | 1 | Sink register access request |
| aux_wr | output | 1 | Access is a write |
| aux_addr | output | ADDR_W | Sink register address |
| aux_wdata | output | 8 | Write byte |
| aux_done | input | 1 | One-cycle acknowledge that ends an access |
| aux_rdata | input | 8 | Read byte, valid with aux_done |
| tx_pattern | output | 2 | Transmitter pattern: 0 off, 1 pattern 1, 2 pattern 2 |
| tx_swing | output | 8 | Swing level, two bits per lane, lane 0 lowest |
| tx_pre | output | 8 | Pre-emphasis level, two bits per lane, lane 0 lowest |

## Verification
The hardest cases to reach are the loop-limit exits, because each one needs the sink to answer many polls in one particular way. The repeat-counter exit also starts from a transmitter state that differs from what was written to the sink. A scripted sink model counts status polls and decides from the poll index whether clock recovery is done, whether equalization is done or whether clock recovery has been lost. It returns a fixed request nibble, and a mask that clears chosen lanes' nibbles. With this one mechanism each scenario reaches a chosen exit at a known poll number, and the bench checks the poll count exactly.

// File: rtl/dp_link_trainer.sv
module dp_link_trainer #(
  parameter int ADDR_W    = 20,
  parameter int MAX_CR    = 5,
  parameter int MAX_EQ    = 5,
  parameter int POLL_WAIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [7:0]        link_rate,
  output logic [2:0]        link_lanes,
  output logic              aux_req,
  output logic              aux_wr,
  output logic [ADDR_W-1:0] aux_addr,
  output logic [7:0]        aux_wdata,
  input  logic              aux_done,
  input  logic [7:0]        aux_rdata,
  output logic [1:0]        tx_pattern,
  output logic [7:0]        tx_swing,
  output logic [7:0]        tx_pre
);
  localparam int CRW = $clog2(MAX_CR + 1);
  localparam int EQW = $clog2(MAX_EQ + 1);
  localparam int WW  = $clog2(POLL_WAIT + 1);

  localparam logic [ADDR_W-1:0] A_CAP_RATE = ADDR_W'(12'h001);
  localparam logic [ADDR_W-1:0] A_CAP_LANE = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] A_RATE     = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_COUNT    = ADDR_W'(12'h101);
  localparam logic [ADDR_W-1:0] A_PATTERN  = ADDR_W'(12'h102);
  localparam logic [ADDR_W-1:0] A_SET0     = ADDR_W'(12'h103);
  localparam logic [ADDR_W-1:0] A_STAT0    = ADDR_W'(12'h202);
  localparam logic [ADDR_W-1:0] A_STAT1    = ADDR_W'(12'h203);
  localparam logic [ADDR_W-1:0] A_ALIGN    = ADDR_W'(12'h204);
  localparam logic [ADDR_W-1:0] A_ADJ0     = ADDR_W'(12'h206);
  localparam logic [ADDR_W-1:0] A_ADJ1     = ADDR_W'(12'h207);
  localparam logic [ADDR_W-1:0] A_POWER    = ADDR_W'(12'h600);

  typedef enum logic [3:0] {
    S_IDLE, S_RATE, S_LCNT, S_PWR, S_BW, S_CNT, S_PAT, S_SET,
    S_WAIT, S_ST0, S_ST1, S_ALN, S_ADJ0, S_ADJ1, S_EVAL, S_OFF
  } state_t;

  state_t state;
  logic   eq_phase, ok;
  logic [1:0]            idx;
  logic [WW-1:0]         wcnt;
  logic [3:0][2:0]       st_q;
  logic                  aln_q;
  logic [15:0]           adj_q;
  logic [3:0][7:0]       set_q;
  logic [3:0][CRW-1:0]   cr_cnt;
  logic [EQW-1:0]        eq_cnt;

  logic [3:0]      act, same;
  logic [3:0][1:0] rv, rp;
  logic [3:0][7:0] new_set;
  logic            cr_ok, eq_ok, cr_bad;

  always_comb begin
    cr_ok  = 1'b1;
    eq_ok  = aln_q;
    cr_bad = 1'b0;
    for (int n = 0; n < 4; n++) begin
      act[n]     = 3'(n) < link_lanes;
      rv[n]      = adj_q[4*n +: 2];
      rp[n]      = adj_q[4*n+2 +: 2];
      new_set[n] = {2'b00, rp[n] == 2'd3, rp[n], rv[n] == 2'd3, rv[n]};
      same[n]    = act[n] && tx_swing[2*n +: 2] == rv[n] && tx_pre[2*n +: 2] == rp[n];
      if (act[n] && !st_q[n][0])          cr_ok = 1'b0;
      if (act[n] && st_q[n] != 3'b111)    eq_ok = 1'b0;
      if (act[n] && (rv[n] == 2'd3 || rp[n] == 2'd3)) cr_bad = 1'b1;
      if (same[n] && cr_cnt[n] == CRW'(MAX_CR - 1))   cr_bad = 1'b1;
    end
  end

  always_comb begin
    aux_req   = 1'b1;
    aux_wr    = 1'b0;
    aux_addr  = '0;
    aux_wdata = 8'h00;
    case (state)
      S_RATE: aux_addr = A_CAP_RATE;
      S_LCNT: aux_addr = A_CAP_LANE;
      S_PWR:  begin aux_wr = 1'b1; aux_addr = A_POWER;   aux_wdata = 8'h01; end
      S_BW:   begin aux_wr = 1'b1; aux_addr = A_RATE;    aux_wdata = link_rate; end
      S_CNT:  begin aux_wr = 1'b1; aux_addr = A_COUNT;   aux_wdata = {5'd0, link_lanes}; end
      S_PAT:  begin aux_wr = 1'b1; aux_addr = A_PATTERN; aux_wdata = eq_phase ? 8'h22 : 8'h21; end
      S_SET:  begin aux_wr = 1'b1; aux_addr = A_SET0 + ADDR_W'(idx); aux_wdata = set_q[idx]; end
      S_ST0:  aux_addr = A_STAT0;
      S_ST1:  aux_addr = A_STAT1;
      S_ALN:  aux_addr = A_ALIGN;
      S_ADJ0: aux_addr = A_ADJ0;
      S_ADJ1: aux_addr = A_ADJ1;
      S_OFF:  begin aux_wr = 1'b1; aux_addr = A_PATTERN; aux_wdata = 8'h00; end
      default: aux_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      ok         <= 1'b0;
      eq_phase   <= 1'b0;
      link_rate  <= 8'h00;
      link_lanes <= 3'd0;
      tx_pattern <= 2'd0;
      tx_swing   <= 8'h00;
      tx_pre     <= 8'h00;
      idx        <= 2'd0;
      wcnt       <= '0;
      st_q       <= '0;
      aln_q      <= 1'b0;
      adj_q      <= 16'h0000;
      set_q      <= '0;
      cr_cnt     <= '0;
      eq_cnt     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          done     <= 1'b0;
          pass     <= 1'b0;
          eq_phase <= 1'b0;
          state    <= S_RATE;
        end
        S_RATE: if (aux_done) begin
          link_rate <= (aux_rdata == 8'h06 || aux_rdata == 8'h0A) ? aux_rdata : 8'h06;
          state     <= S_LCNT;
        end
        S_LCNT: if (aux_done) begin
          link_lanes <= (aux_rdata[4:0] == 5'd1) ? 3'd1 :
                        (aux_rdata[4:0] == 5'd2) ? 3'd2 : 3'd4;
          state      <= S_PWR;
        end
        S_PWR: if (aux_done) state <= S_BW;
        S_BW:  if (aux_done) state <= S_CNT;
        S_CNT: if (aux_done) begin
          tx_pattern <= 2'd1;
          for (int n = 0; n < 4; n++) begin
            tx_swing[2*n +: 2] <= 2'd0;
            tx_pre[2*n +: 2]   <= act[n] ? 2'd1 : 2'd0;
          end
          set_q  <= '0;
          cr_cnt <= '0;
          eq_cnt <= '0;
          state  <= S_PAT;
        end
        S_PAT: if (aux_done) begin
          idx   <= 2'd0;
          state <= S_SET;
        end
        S_SET: if (aux_done) begin
          if ({1'b0, idx} == link_lanes - 3'd1) begin
            idx   <= 2'd0;
            state <= S_WAIT;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_WAIT: begin
          if (wcnt == WW'(POLL_WAIT - 1)) begin
            wcnt  <= '0;
            state <= S_ST0;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        S_ST0: if (aux_done) begin
          st_q[0] <= aux_rdata[2:0];
          st_q[1] <= aux_rdata[6:4];
          state   <= S_ST1;
        end
        S_ST1: if (aux_done) begin
          st_q[2] <= aux_rdata[2:0];
          st_q[3] <= aux_rdata[6:4];
          state   <= eq_phase ? S_ALN : S_ADJ0;
        end
        S_ALN: if (aux_done) begin
          aln_q <= aux_rdata[0];
          state <= S_ADJ0;
        end
        S_ADJ0: if (aux_done) begin
          adj_q[7:0] <= aux_rdata;
          state      <= S_ADJ1;
        end
        S_ADJ1: if (aux_done) begin
          adj_q[15:8] <= aux_rdata;
          state       <= S_EVAL;
        end
        S_EVAL: begin
          if ((!eq_phase && !cr_ok && cr_bad) || (eq_phase && !cr_ok) ||
              (eq_phase && !eq_ok && eq_cnt == EQW'(MAX_EQ))) begin
            ok         <= 1'b0;
            tx_pattern <= 2'd0;
            state      <= S_OFF;
          end else if (eq_phase && eq_ok) begin
            ok         <= 1'b1;
            tx_pattern <= 2'd0;
            state      <= S_OFF;
          end else begin
            for (int n = 0; n < 4; n++) begin
              if (act[n]) begin
                tx_swing[2*n +: 2] <= rv[n];
                tx_pre[2*n +: 2]   <= rp[n];
                set_q[n]           <= new_set[n];
                if (!eq_phase && !cr_ok && same[n]) cr_cnt[n] <= cr_cnt[n] + CRW'(1);
              end
            end
            if (!eq_phase && cr_ok) begin
              eq_phase   <= 1'b1;
              tx_pattern <= 2'd2;
              state      <= S_PAT;
            end else begin
              if (eq_phase) eq_cnt <= eq_cnt + EQW'(1);
              idx   <= 2'd0;
              state <= S_SET;
            end
          end
        end
        S_OFF: if (aux_done) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          pass  <= ok;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dp_link_trainer_chk.sv
module dp_link_trainer_chk #(
  parameter int ADDR_W    = 20,
  parameter int POLL_WAIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aux_req,
  input logic              aux_done,
  input logic [ADDR_W-1:0] aux_addr,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [1:0]        tx_pattern
);
  localparam int CW = $clog2(POLL_WAIT + 2);

  logic          req_d;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      req_d <= aux_req;
      if (aux_req) idle_cnt <= '0;
      else if (idle_cnt != CW'(POLL_WAIT + 1)) idle_cnt <= idle_cnt + CW'(1);
    end
  end

  // R11
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && !req_d && aux_addr == ADDR_W'(12'h202)) |-> (idle_cnt >= CW'(POLL_WAIT)));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && !aux_done) |=> (aux_req && $stable(aux_addr)));

  // R12
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R8
  pattern_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_pattern == 2'd0));
endmodule

bind dp_link_trainer dp_link_trainer_chk #(.ADDR_W(ADDR_W), .POLL_WAIT(POLL_WAIT)) chk_i (.*);

// File: tb/dp_link_trainer_tb_top.sv
module dp_link_trainer_tb_top;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, aux_req, aux_wr;
  logic [7:0] link_rate, aux_wdata, tx_swing, tx_pre;
  logic [2:0] link_lanes;
  logic [19:0] aux_addr;
  logic aux_done = 1'b0;
  logic [7:0] aux_rdata = 8'h00;
  logic [1:0] tx_pattern;

  always #10 clk = ~clk;

  dp_link_trainer #(.POLL_WAIT(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .link_rate(link_rate), .link_lanes(link_lanes), .aux_req(aux_req), .aux_wr(aux_wr),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_done(aux_done), .aux_rdata(aux_rdata),
    .tx_pattern(tx_pattern), .tx_swing(tx_swing), .tx_pre(tx_pre));

  typedef struct packed {
    logic [7:0]  rate_cap;
    logic [7:0]  lane_cap;
    logic [3:0]  adj;
    logic [15:0] mask;
    logic [7:0]  cr_at, eq_at, lose_at;
    logic        e_pass;
    logic [7:0]  e_rate;
    logic [2:0]  e_lanes;
    logic [7:0]  e_polls;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h0A, 8'h02, 4'h1, 16'hFFFF, 8'd1,   8'd3,   8'd255, 1'b1, 8'h0A, 3'd2, 8'd4}, // R5 R8 success
    '{8'h06, 8'h04, 4'h0, 16'hFFFF, 8'd255, 8'd255, 8'd255, 1'b0, 8'h06, 3'd4, 8'd6}, // R7 repeat limit
    '{8'h33, 8'h00, 4'h5, 16'hFFFF, 8'd0,   8'd255, 8'd255, 1'b0, 8'h06, 3'd4, 8'd7}, // R9 R1 R2 eq limit
    '{8'h0A, 8'h01, 4'h3, 16'hFFFF, 8'd255, 8'd255, 8'd255, 1'b0, 8'h0A, 3'd1, 8'd1}, // R6 level 3
    '{8'h06, 8'h01, 4'hF, 16'hFFFF, 8'd0,   8'd1,   8'd255, 1'b1, 8'h06, 3'd1, 8'd2}, // R5 level 3 ok
    '{8'h06, 8'h02, 4'h5, 16'hFFFF, 8'd0,   8'd255, 8'd2,   1'b0, 8'h06, 3'd2, 8'd3}, // R10 cr lost
    '{8'h06, 8'h02, 4'h1, 16'hFF0F, 8'd0,   8'd1,   8'd255, 1'b0, 8'h06, 3'd2, 8'd6}, // R4 lane1 high nibble
    '{8'h06, 8'h01, 4'h1, 16'hFF0F, 8'd0,   8'd1,   8'd255, 1'b1, 8'h06, 3'd1, 8'd2}, // R2 inactive lane
    '{8'h0A, 8'h04, 4'h1, 16'h0FFF, 8'd0,   8'd1,   8'd255, 1'b0, 8'h0A, 3'd4, 8'd6}  // R4 lane3 byte1
  };

  localparam int NE = 14;
  localparam logic [19:0] EXP_LOG [NE] = '{
    {12'h600, 8'h01}, {12'h100, 8'h0A}, {12'h101, 8'h02}, {12'h102, 8'h21},
    {12'h103, 8'h00}, {12'h104, 8'h00}, {12'h103, 8'h01}, {12'h104, 8'h01},
    {12'h102, 8'h22}, {12'h103, 8'h01}, {12'h104, 8'h01}, {12'h103, 8'h01},
    {12'h104, 8'h01}, {12'h102, 8'h00}};

  vec_t cfg;
  int   polls, cur_poll, nlog, idle_run, min_idle, lat;
  logic req_prev;
  logic [19:0] wlog [64];
  int   total = 0, fails = 0, cycles = 0;

  function automatic logic [7:0] stat_byte(int k);
    if (k >= int'(cfg.lose_at)) return 8'h00;
    if (k < int'(cfg.cr_at))    return 8'h00;
    if (k < int'(cfg.eq_at))    return 8'h11;
    return 8'h77;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      aux_done <= 1'b0; lat = 0; req_prev = 1'b0; idle_run = 0;
    end else begin
      if (!aux_req) idle_run++;
      else if (!req_prev) begin
        if (aux_addr == 20'h202 && idle_run < min_idle) min_idle = idle_run;
        idle_run = 0;
      end
      req_prev = aux_req;
      if (aux_done) aux_done <= 1'b0;
      else if (aux_req) begin
        if (lat == 1) begin
          lat = 0;
          aux_done <= 1'b1;
          if (aux_wr) begin
            if (nlog < 64) wlog[nlog] = {aux_addr[11:0], aux_wdata};
            nlog++;
          end else begin
            case (aux_addr[11:0])
              12'h001: aux_rdata <= cfg.rate_cap;
              12'h002: aux_rdata <= cfg.lane_cap;
              12'h202: begin cur_poll = polls; polls++; aux_rdata <= stat_byte(cur_poll) & cfg.mask[7:0]; end
              12'h203: aux_rdata <= stat_byte(cur_poll) & cfg.mask[15:8];
              12'h204: aux_rdata <= (stat_byte(cur_poll) == 8'h77) ? 8'h01 : 8'h00;
              12'h206, 12'h207: aux_rdata <= {cfg.adj, cfg.adj};
              default: aux_rdata <= 8'h00;
            endcase
          end
        end else lat++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; total++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cfg = VECS[0];
    polls = 0; nlog = 0; min_idle = 1000;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 pass", pass, 0);
    chk("R12 aux_req", aux_req, 0);
    chk("R12 tx_pattern", tx_pattern, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 idle without start", busy, 0);

    for (int v = 0; v < NV; v++) begin
      cfg = VECS[v];
      polls = 0; nlog = 0; min_idle = 1000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R12 busy after start", busy, 1);
      chk("R12 done cleared", done, 0);
      while (!done) @(negedge clk);
      chk("R8 pass outcome", pass, cfg.e_pass);
      chk("R1 link_rate", link_rate, cfg.e_rate);
      chk("R2 link_lanes", link_lanes, cfg.e_lanes);
      chk("R7 R9 status poll count", polls, cfg.e_polls);
      chk("R8 tx_pattern off", tx_pattern, 0);
      chk("R8 final pattern write", wlog[nlog-1], {12'h102, 8'h00});
      chk("R11 poll gap", (min_idle >= PW) ? 1 : 0, 1);
      chk("R3 first write power", wlog[0], {12'h600, 8'h01});
      chk("R2 start lane writes", nlog >= 4 + int'(cfg.e_lanes), 1);
      chk("R2 last start lane write", wlog[3 + int'(cfg.e_lanes)],
          {12'h103 + 12'(cfg.e_lanes) - 12'd1, 8'h00});
      if (v == 0) begin
        chk("R3 R5 write count", nlog, NE);
        for (int i = 0; i < NE; i++) chk("R3 R5 write sequence", wlog[i], EXP_LOG[i]);
      end
      if (v == 4) begin
        chk("R5 level 3 swing applied", tx_swing, 8'h03);
        chk("R5 level 3 pre applied", tx_pre, 8'h03);
        chk("R4 max flags in set byte", wlog[nlog-2], {12'h103, 8'h3F});
      end
      if (v == 3) chk("R6 no lane rewrite", nlog, 6);
      repeat (3) @(negedge clk);
    end

    // R3 transmitter state during start phase
    cfg = VECS[1];
    polls = 0; nlog = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (nlog < 4) @(negedge clk);
    chk("R3 tx_pattern 1", tx_pattern, 1);
    chk("R3 tx_pre level 1", tx_pre, 8'h55);
    chk("R3 tx_swing level 0", tx_swing, 8'h00);
    while (!done) @(negedge clk);
    chk("R7 repeat fail", pass, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule